// File: doc/BRIEF.md
# Dual-Mode Multiplexed Bus Slave Interface

This block is the host-side front end of a clock peripheral that sits on a shared 8-bit address/data bus. An address strobe marks the address phase; the block catches the address byte and a bank-select line when that strobe falls. During the data phase it turns the data and direction strobes into single-cycle internal read and write pulses. It also tells the register logic behind it which region the access targets, and it drives the read byte back onto the bus.

A mode pin selects one of two strobe conventions. In the first, a data strobe qualified by a direction level is used. In the second, separate active-low read and write strobes are used. The mode is taken once, while reset is held, and is then fixed. All bus inputs pass through a two-stage synchroniser clocked by the system clock, and edges are found on the synchronised copies. An internal strobe therefore appears three clock edges after the bus edge that caused it. Address and write data must stay on the bus for at least four clocks after their strobe edge. The block filters writes to read-only control locations and blocks every write while the write-protect input is high. The register and storage arrays themselves are outside the block.

Top module: `mux_bus_slave`

## Requirements
- R1: The falling edge of `as_i` captures `ad_i` into `reg_addr` and `ext_i` into the bank select. This capture happens whether or not the chip is selected.
- R2: With the mode sampled high, a read starts on a rising `ds_i` while `rw_i` is high. It drives `ad_oe` high with the read byte on `ad_o` until `ds_i` falls. A write is taken on a falling `ds_i` while `rw_i` is low.
- R3: With the mode sampled low, a falling `ds_i` starts a read. The read holds `ad_oe` high until `ds_i` rises. A rising `rw_i` takes a write of the byte on `ad_i`.
- R4: An access takes effect only if `cs_n_i` is low at the data strobe edge. A deselected access gives no `reg_wr` pulse, does not raise `ad_oe`, and leaves the target unchanged.
- R5: `reg_sel` encodes the target region. The value 3 means the extended bank, selected by `ext_i` high. When `ext_i` is low: 0 covers addresses 0x00–0x09 (clock), 1 covers 0x0A–0x0D (control), and 2 covers 0x0E and above (storage).
- R6: Writes to control addresses 0x0C and 0x0D give no `reg_wr` pulse. A write to 0x0A carries `reg_wmask` 0x7F, so bit 7 is kept. A read of 0x0D returns `valid_i` in bit 7 and zeros in the other bits.
- R7: While `rst_n` is low, no access is accepted: `reg_wr`, `reg_rd` and `ad_oe` stay low.
- R8: A write that is taken while `wprot_i` is high gives no `reg_wr` pulse, and the target keeps its old value.
- R9: The mode is taken from `mode_i` only while `rst_n` is low. Later changes of `mode_i` do not change how the strobes are read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset; also samples the mode |
| mode_i | input | 1 | Strobe convention: 1 = data strobe plus direction, 0 = separate read/write strobes |
| as_i | input | 1 | Address strobe; falling edge captures the address |
| ds_i | input | 1 | Data strobe (mode 1) or active-low read strobe (mode 0) |
| rw_i | input | 1 | Direction level (mode 1, high = read) or active-low write strobe (mode 0) |
| cs_n_i | input | 1 | Active-low chip select for the data phase |
| ext_i | input | 1 | Extended bank select, captured with the address |
| wprot_i | input | 1 | Write protect during power loss |
| valid_i | input | 1 | Valid-backup flag returned in bit 7 of address 0x0D |
| ad_i | input | 8 | Bus value seen at the pins (address or write data) |
| reg_rdata | input | 8 | Read byte from the addressed register or storage |
| ad_o | output | 8 | Read byte driven to the bus |
| ad_oe | output | 1 | Bus output enable during a read |
| reg_addr | output | 8 | Latched address |
| reg_sel | output | 2 | Target region code |
| reg_rd | output | 1 | One-cycle read pulse |
| reg_wr | output | 1 | One-cycle write pulse |
| reg_wdata | output | 8 | Captured write byte |
| reg_wmask | output | 8 | Bit-write mask for the write |

## Verification
The bench runs the same table of accesses in both strobe conventions. A design that confused the conventions would either miss every read, so `ad_oe` would never rise, or latch the wrong byte. An address phase is run with the chip deselected and is then followed by a selected write. This catches a design that gates address capture with chip select, which would write to a stale address. The read-only filter is probed by writing 0x0C, 0x0D and 0xFF into 0x0A and reading each back. A missing mask would show bit 7 of 0x0A set, and a missing filter would let 0x0C or 0x0D change. Finally, the mode pin is flipped after reset and accesses are attempted while reset is held. A design that reads the live mode pin would lose the following read, and one that is not held idle in reset would count a write.

// File: rtl/mux_bus_slave.sv
module mux_bus_slave #(
  parameter int DW        = 8,
  parameter int CLK_REGS  = 10,
  parameter int CTRL_REGS = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          mode_i,
  input  logic          as_i,
  input  logic          ds_i,
  input  logic          rw_i,
  input  logic          cs_n_i,
  input  logic          ext_i,
  input  logic          wprot_i,
  input  logic          valid_i,
  input  logic [DW-1:0] ad_i,
  input  logic [DW-1:0] reg_rdata,
  output logic [DW-1:0] ad_o,
  output logic          ad_oe,
  output logic [DW-1:0] reg_addr,
  output logic [1:0]    reg_sel,
  output logic          reg_rd,
  output logic          reg_wr,
  output logic [DW-1:0] reg_wdata,
  output logic [DW-1:0] reg_wmask
);
  localparam logic [DW-1:0] CTRL_LO  = DW'(CLK_REGS);
  localparam logic [DW-1:0] CTRL_END = DW'(CLK_REGS + CTRL_REGS);
  localparam logic [DW-1:0] RO_LO    = DW'(CLK_REGS + 2);
  localparam logic [DW-1:0] STAT_A   = DW'(CLK_REGS + 3);
  localparam logic [DW-1:0] TOP_MASK = {1'b0, {(DW-1){1'b1}}};

  // synchroniser stages, bit order {as, ds, rw, cs_n}
  logic [3:0] s1, s2, sp;
  logic       mode_q, ext_q;

  wire as_fall = sp[3] & ~s2[3];
  wire ds_rise = ~sp[2] & s2[2];
  wire ds_fall = sp[2] & ~s2[2];
  wire rw_rise = ~sp[1] & s2[1];
  wire sel_ok  = ~s2[0];

  wire rd_go  = sel_ok & (mode_q ? (ds_rise & s2[1]) : ds_fall);
  wire wr_go  = sel_ok & (mode_q ? (ds_fall & ~s2[1]) : rw_rise);
  wire rd_end = mode_q ? ds_fall : ds_rise;

  always_comb begin
    if (ext_q)                  reg_sel = 2'd3;
    else if (reg_addr < CTRL_LO)  reg_sel = 2'd0;
    else if (reg_addr < CTRL_END) reg_sel = 2'd1;
    else                        reg_sel = 2'd2;
  end

  wire ctrl_hit = (reg_sel == 2'd1);
  wire ro_hit   = ctrl_hit & (reg_addr >= RO_LO);
  wire stat_hit = ctrl_hit & (reg_addr == STAT_A);
  wire top_hit  = ctrl_hit & (reg_addr == CTRL_LO);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mode_q    <= mode_i;
      s1        <= 4'b0111;
      s2        <= 4'b0111;
      sp        <= 4'b0111;
      reg_addr  <= '0;
      ext_q     <= 1'b0;
      reg_rd    <= 1'b0;
      reg_wr    <= 1'b0;
      reg_wdata <= '0;
      reg_wmask <= '0;
      ad_o      <= '0;
      ad_oe     <= 1'b0;
    end else begin
      s1     <= {as_i, ds_i, rw_i, cs_n_i};
      s2     <= s1;
      sp     <= s2;
      reg_rd <= rd_go;
      reg_wr <= wr_go & ~wprot_i & ~ro_hit;
      if (as_fall) begin
        reg_addr <= ad_i;
        ext_q    <= ext_i;
      end
      if (wr_go) begin
        reg_wdata <= ad_i;
        reg_wmask <= top_hit ? TOP_MASK : '1;
      end
      if (rd_go) begin
        ad_o  <= stat_hit ? {valid_i, {(DW-1){1'b0}}} : reg_rdata;
        ad_oe <= 1'b1;
      end else if (rd_end || !sel_ok) begin
        ad_oe <= 1'b0;
      end
    end
  end
endmodule

module mux_bus_slave_chk #(
  parameter int DW        = 8,
  parameter int CLK_REGS  = 10
) (
  input logic          clk,
  input logic          rst_n,
  input logic          wprot_i,
  input logic          cs_sync,
  input logic          reg_wr,
  input logic          reg_rd,
  input logic          ad_oe,
  input logic [1:0]    reg_sel,
  input logic [DW-1:0] reg_addr,
  input logic [DW-1:0] reg_wmask
);
  localparam logic [DW-1:0] RO_LO  = DW'(CLK_REGS + 2);
  localparam logic [DW-1:0] TOP_A  = DW'(CLK_REGS);

  assert_wprot_blocks_R8: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |-> !$past(wprot_i));
  assert_cs_gates_R4: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |-> !$past(cs_sync));
  assert_ro_filtered_R6: assert property (@(posedge clk) disable iff (!rst_n)
    reg_wr |-> !(reg_sel == 2'd1 && reg_addr >= RO_LO));
  assert_top_bit_masked_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (reg_wr && reg_sel == 2'd1 && reg_addr == TOP_A) |-> !reg_wmask[DW-1]);
  assert_oe_from_read_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(ad_oe) |-> reg_rd);
  assert_one_strobe_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !(reg_wr && reg_rd));
endmodule

bind mux_bus_slave mux_bus_slave_chk #(.DW(DW), .CLK_REGS(CLK_REGS)) u_chk (
  .clk(clk), .rst_n(rst_n), .wprot_i(wprot_i), .cs_sync(s2[0]),
  .reg_wr(reg_wr), .reg_rd(reg_rd), .ad_oe(ad_oe), .reg_sel(reg_sel),
  .reg_addr(reg_addr), .reg_wmask(reg_wmask)
);

// File: tb/tb_mux_bus_slave.sv
module tb_mux_bus_slave;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0, mode_i = 1, as_i = 0, ds_i = 0, rw_i = 1, cs_n_i = 1;
  logic ext_i = 0, wprot_i = 0, valid_i = 1;
  logic [7:0] ad_i = 0, reg_rdata, ad_o, reg_addr, reg_wdata, reg_wmask;
  logic ad_oe, reg_rd, reg_wr;
  logic [1:0] reg_sel;

  always #(CLK_PERIOD/2) clk = ~clk;

  mux_bus_slave dut (
    .clk(clk), .rst_n(rst_n), .mode_i(mode_i), .as_i(as_i), .ds_i(ds_i), .rw_i(rw_i),
    .cs_n_i(cs_n_i), .ext_i(ext_i), .wprot_i(wprot_i), .valid_i(valid_i), .ad_i(ad_i),
    .reg_rdata(reg_rdata), .ad_o(ad_o), .ad_oe(ad_oe), .reg_addr(reg_addr),
    .reg_sel(reg_sel), .reg_rd(reg_rd), .reg_wr(reg_wr), .reg_wdata(reg_wdata),
    .reg_wmask(reg_wmask)
  );

  // storage model behind the interface
  logic [7:0] mem [256];
  int wr_cnt = 0;
  logic [7:0] last_addr = 0;
  logic [1:0] last_sel = 0;
  assign reg_rdata = mem[{reg_sel == 2'd3, reg_addr[6:0]}];
  always @(posedge clk) if (reg_wr) begin
    wr_cnt = wr_cnt + 1;
    last_addr <= reg_addr;
    last_sel  <= reg_sel;
    mem[{reg_sel == 2'd3, reg_addr[6:0]}] <=
      (mem[{reg_sel == 2'd3, reg_addr[6:0]}] & ~reg_wmask) | (reg_wdata & reg_wmask);
  end

  int checks = 0, fails = 0;
  bit mmode = 1;

  task automatic chk(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic do_reset(input bit m);
    @(negedge clk);
    rst_n = 0; mode_i = m; mmode = m; as_i = 0; ds_i = m ? 1'b0 : 1'b1; rw_i = 1; cs_n_i = 1;
    repeat (5) @(negedge clk);
    rst_n = 1;
    repeat (5) @(negedge clk);
    cs_n_i = 0;
  endtask

  task automatic addr_ph(input logic e, input logic [7:0] a);
    @(negedge clk); ad_i = a; ext_i = e; as_i = 1;
    repeat (4) @(negedge clk); as_i = 0;
    repeat (4) @(negedge clk);
  endtask

  task automatic wr_ph(input logic [7:0] d);
    @(negedge clk); ad_i = d; rw_i = 0;
    if (mmode) begin
      repeat (2) @(negedge clk); ds_i = 1;
      repeat (4) @(negedge clk); ds_i = 0;
      repeat (4) @(negedge clk); rw_i = 1;
    end else begin
      repeat (4) @(negedge clk); rw_i = 1;
      repeat (4) @(negedge clk);
    end
    repeat (2) @(negedge clk);
  endtask

  task automatic rd_ph(input logic [7:0] exp, input bit expect_oe, input string tag);
    @(negedge clk);
    if (mmode) begin rw_i = 1; ds_i = 1; end else ds_i = 0;
    repeat (6) @(negedge clk);
    chk(ad_oe == expect_oe, tag, {7'b0, ad_oe}, {7'b0, expect_oe});
    if (expect_oe) chk(ad_o == exp, tag, ad_o, exp);
    ds_i = mmode ? 1'b0 : 1'b1;
    repeat (6) @(negedge clk);
    chk(ad_oe == 1'b0, tag, {7'b0, ad_oe}, 8'h00);
  endtask

  // {write, ext, addr, data, expected read}
  localparam logic [25:0] VEC [15] = '{
    {1'b1, 1'b0, 8'h05, 8'h23, 8'h00}, {1'b0, 1'b0, 8'h05, 8'h00, 8'h23},
    {1'b1, 1'b1, 8'h05, 8'h9C, 8'h00}, {1'b0, 1'b1, 8'h05, 8'h00, 8'h9C},
    {1'b0, 1'b0, 8'h05, 8'h00, 8'h23}, {1'b1, 1'b0, 8'h0A, 8'hFF, 8'h00},
    {1'b0, 1'b0, 8'h0A, 8'h00, 8'h7F}, {1'b1, 1'b0, 8'h0C, 8'hAA, 8'h00},
    {1'b0, 1'b0, 8'h0C, 8'h00, 8'h00}, {1'b1, 1'b0, 8'h0D, 8'h55, 8'h00},
    {1'b0, 1'b0, 8'h0D, 8'h00, 8'h80}, {1'b1, 1'b0, 8'h40, 8'h3C, 8'h00},
    {1'b0, 1'b0, 8'h40, 8'h00, 8'h3C}, {1'b1, 1'b1, 8'h7F, 8'hE1, 8'h00},
    {1'b0, 1'b1, 8'h7F, 8'h00, 8'hE1}
  };

  initial begin
    for (int i = 0; i < 256; i++) mem[i] = 8'h00;
    do_reset(1'b1);
    chk(ad_oe == 0 && reg_wr == 0 && reg_rd == 0, "R7 reset state", {5'b0, ad_oe, reg_wr, reg_rd}, 8'h00);

    for (int p = 0; p < 2; p++) begin
      int base;
      do_reset(p == 0);
      base = wr_cnt;
      for (int i = 0; i < 15; i++) begin
        addr_ph(VEC[i][24], VEC[i][23:16]);
        if (VEC[i][25]) wr_ph(VEC[i][15:8]);
        else rd_ph(VEC[i][7:0], 1'b1, p == 0 ? "R2 R5 R6 table read" : "R3 R5 R6 table read");
      end
      chk(wr_cnt - base == 5, "R6 write count per pass", 8'(wr_cnt - base), 8'd5);
    end

    // R5 region codes
    do_reset(1'b1);
    addr_ph(0, 8'h03); wr_ph(8'h01); chk(last_sel == 0, "R5 clock region", {6'b0, last_sel}, 8'd0);
    addr_ph(0, 8'h0B); wr_ph(8'h02); chk(last_sel == 1, "R5 control region", {6'b0, last_sel}, 8'd1);
    addr_ph(0, 8'h20); wr_ph(8'h03); chk(last_sel == 2, "R5 storage region", {6'b0, last_sel}, 8'd2);
    addr_ph(1, 8'h20); wr_ph(8'h04); chk(last_sel == 3, "R5 extended region", {6'b0, last_sel}, 8'd3);

    // R1 address captured while deselected
    cs_n_i = 1;
    addr_ph(0, 8'h22);
    cs_n_i = 0;
    wr_ph(8'h5A);
    chk(last_addr == 8'h22, "R1 address capture without select", last_addr, 8'h22);
    rd_ph(8'h5A, 1'b1, "R1 readback");

    // R4 deselected data phase
    begin
      int c0;
      c0 = wr_cnt;
      cs_n_i = 1;
      wr_ph(8'h11);
      chk(wr_cnt == c0, "R4 deselected write", 8'(wr_cnt - c0), 8'd0);
      rd_ph(8'h00, 1'b0, "R4 deselected read");
      cs_n_i = 0;
      rd_ph(8'h5A, 1'b1, "R4 value kept");

      // R8 write protect
      c0 = wr_cnt;
      wprot_i = 1;
      wr_ph(8'h77);
      wprot_i = 0;
      chk(wr_cnt == c0, "R8 protected write", 8'(wr_cnt - c0), 8'd0);
      rd_ph(8'h5A, 1'b1, "R8 value kept");

      // R7 accesses during reset
      c0 = wr_cnt;
      @(negedge clk); rst_n = 0;
      addr_ph(0, 8'h30);
      wr_ph(8'h99);
      rd_ph(8'h00, 1'b0, "R7 read in reset");
      chk(wr_cnt == c0, "R7 write in reset", 8'(wr_cnt - c0), 8'd0);
      rst_n = 1;
      repeat (5) @(negedge clk);

      // R9 mode pin change after reset
      do_reset(1'b1);
      mode_i = 0;
      c0 = wr_cnt;
      addr_ph(0, 8'h31);
      wr_ph(8'h66);
      chk(wr_cnt == c0 + 1, "R9 write after mode pin change", 8'(wr_cnt - c0), 8'd1);
      rd_ph(8'h66, 1'b1, "R9 read after mode pin change");
    end

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    fails++;
    $display("FAIL watchdog expired act=%h exp=%h", 8'h00, 8'h01);
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule